// File: doc/BRIEF.md
# Segment Access-Rights Checker

This unit answers one question for a protected-mode core: given a 16-bit segment selector and the current privilege level, may software read the access-rights part of the segment descriptor? If so, what is its value? The selector's table-indicator bit picks either the global or the local descriptor table. The unit checks the selector against that table's limit. It then reads the upper 32-bit word of the 8-byte descriptor through a request/valid memory port. The descriptor type and privilege tests run on the returned word.

When every test passes, the unit raises its zero flag and loads a masked copy of the descriptor word into its result register. The mask depends on the requested operand size (16 or 32 bits). When any test fails, the flag is cleared and the result register keeps its previous value. If the core is not in protected mode, the unit rejects the request and flags an invalid operation. A failed selector or limit test ends the request without a memory access. Every request ends with a one-cycle completion pulse.

Top module: `segAccessCheck`

## Requirements
- R1: After reset, `done`, `zf`, `badOp` and `memReq` are low and `rights` is zero.
- R2: A `start` with `protMode` low completes with `done` high in the next cycle, `badOp` high and `zf` low, and no memory request is made.
- R3: A selector whose bits 15:2 are all zero is null: it completes in the next cycle with `zf` low and no memory request. A selector whose index is zero but whose bit 2 is set is not null.
- R4: Bit 2 of the selector picks the table (1 = local, 0 = global). If index*8+7 is greater than that table's limit, where the index is selector bits 15:3, the request fails in the next cycle with no memory request.
- R5: A request that passes R2 to R4 drives `memReq` high from the cycle after `start` until the cycle `memValid` is seen, at the address table base + index*8 + 4, held stable. `done` is high in the cycle after `memValid`.
- R6: A returned word whose bit 12 (segment class) is set describes a code or data segment and always passes the type test.
- R7: With bit 12 clear, the type in bits 11:8 passes only for the values 1, 2, 3, 4, 5, 9, 11 and 12.
- R8: The privilege test passes when both the current level and the selector's requested level (bits 1:0) are less than or equal to the descriptor level in bits 14:13. A conforming code segment (bit 12 set and bits 11:10 both set) skips this test.
- R9: On success with `opSize32` high, `rights` receives the word ANDed with 0x00F0FF00.
- R10: On success with `opSize32` low, `rights` receives the low 16 bits ANDed with 0xFF00, with the upper 16 bits zero.
- R11: On any failure `zf` is low and `rights` keeps its previous value. `badOp` is low after any request that reached the memory fetch.
- R12: `start` is ignored while a fetch is outstanding: it creates no extra completion and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check with the inputs sampled in this cycle |
| selector | input | 16 | Segment selector |
| cpl | input | 2 | Current privilege level |
| opSize32 | input | 1 | 1 = 32-bit result mask, 0 = 16-bit result mask |
| protMode | input | 1 | Core is in protected mode |
| gdtBase | input | ADDR_W | Global table base address |
| gdtLimit | input | 16 | Global table limit in bytes |
| ldtBase | input | ADDR_W | Local table base address |
| ldtLimit | input | 16 | Local table limit in bytes |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | ADDR_W | Address of the descriptor's upper word |
| memValid | input | 1 | Read data is valid this cycle |
| memData | input | 32 | Descriptor upper word |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Check passed |
| badOp | output | 1 | Request made outside protected mode |
| rights | output | 32 | Masked access-rights value |

## Verification
A request that fails before the fetch shows `done`, `zf` and `badOp` one cycle after the `start` cycle. A request that is fetched shows `memReq` and `memAddr` in that same following cycle, and shows its result one cycle after the cycle in which `memValid` is driven. The bench drives every input on the falling edge and reads the outputs on the following falling edges at exactly those offsets. It checks `memReq` and `done` in each waiting cycle, so a result that comes early or late is caught. Read latency is varied from zero to three extra cycles, and one directed request pulses `start` mid-fetch.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef enum logic {ST_IDLE, ST_FETCH} segState_t;

  typedef struct packed {
    logic latchReq;     // capture request, begin fetch
    logic finishEarly;  // complete without fetch (failure)
    logic finishFetch;  // complete with fetched word
  } segStrobe_t;

  localparam logic [31:0] WIDE_MASK   = 32'h00F0_FF00;
  localparam logic [15:0] NARROW_MASK = 16'hFF00;

  // System/gate descriptor types that may be inspected
  function automatic logic sysTypeOk(input logic [3:0] t);
    case (t)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd11, 4'd12: sysTypeOk = 1'b1;
      default:                                          sysTypeOk = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/segchk_ctrl.sv
module segchk_ctrl
  import segchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       earlyPass,
  input  logic       memValid,
  output segStrobe_t strobe,
  output logic       memReq,
  output logic       done
);

  segState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (earlyPass) begin
            strobe.latchReq = 1'b1;
            stateNext       = ST_FETCH;
          end else begin
            strobe.finishEarly = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (memValid) begin
          strobe.finishFetch = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finishEarly | strobe.finishFetch;
    end
  end

  assign memReq = (state == ST_FETCH);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq);
  // R5
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memValid |=> done && !memReq);
  // R5
  no_done_in_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !done);
  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && start && !memValid |=> !done);

endmodule

// File: rtl/segchk_datapath.sv
module segchk_datapath
  import segchk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic [SEL_W-1:0]  selector,
  input  logic [1:0]        cpl,
  input  logic              opSize32,
  input  logic              protMode,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [SEL_W-1:0]  gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [SEL_W-1:0]  ldtLimit,
  input  logic [31:0]       memData,
  output logic              earlyPass,
  output logic [ADDR_W-1:0] memAddr,
  output logic              zf,
  output logic              badOp,
  output logic [31:0]       rights
);

  localparam int IDX_W = SEL_W - 3;

  // ---- early checks on live request inputs ----
  logic [IDX_W-1:0]  idx;
  logic              useLocal;
  logic [ADDR_W-1:0] tblBase;
  logic [SEL_W-1:0]  tblLimit;
  logic [SEL_W-1:0]  lastByte;
  logic              isNull;
  logic              inLimit;
  logic [ADDR_W-1:0] fetchAddr;

  assign idx       = selector[SEL_W-1:3];
  assign useLocal  = selector[2];
  assign tblBase   = useLocal ? ldtBase  : gdtBase;
  assign tblLimit  = useLocal ? ldtLimit : gdtLimit;
  assign lastByte  = {idx, 3'b111};
  assign isNull    = (selector[SEL_W-1:2] == '0);
  assign inLimit   = (lastByte <= tblLimit);
  assign earlyPass = protMode && !isNull && inLimit;
  assign fetchAddr = tblBase + {{(ADDR_W-SEL_W){1'b0}}, idx, 3'b100};

  // ---- captured request ----
  logic [1:0] rplQ, cplQ;
  logic       op32Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      rplQ    <= '0;
      cplQ    <= '0;
      op32Q   <= 1'b0;
    end else if (strobe.latchReq) begin
      memAddr <= fetchAddr;
      rplQ    <= selector[1:0];
      cplQ    <= cpl;
      op32Q   <= opSize32;
    end
  end

  // ---- descriptor evaluation ----
  logic       segClass, conforming, typeOk, privOk, pass;
  logic [3:0] descType;
  logic [1:0] descLvl, effLvl;
  logic [31:0] masked;

  assign segClass   = memData[12];
  assign descType   = memData[11:8];
  assign descLvl    = memData[14:13];
  assign conforming = segClass & descType[3] & descType[2];
  assign typeOk     = segClass | sysTypeOk(descType);
  assign effLvl     = (cplQ > rplQ) ? cplQ : rplQ;
  assign privOk     = conforming | (effLvl <= descLvl);
  assign pass       = typeOk & privOk;
  assign masked     = op32Q ? (memData & WIDE_MASK)
                            : {16'h0000, memData[15:0] & NARROW_MASK};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zf     <= 1'b0;
      badOp  <= 1'b0;
      rights <= '0;
    end else if (strobe.finishEarly) begin
      zf    <= 1'b0;
      badOp <= !protMode;
    end else if (strobe.finishFetch) begin
      badOp <= 1'b0;
      zf    <= pass;
      if (pass) rights <= masked;
    end
  end

  // R9
  rights_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rights & ~WIDE_MASK) == 32'h0);
  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(zf && badOp));

endmodule

// File: rtl/segAccessCheck.sv
module segAccessCheck
  import segchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic              opSize32,
  input  logic              protMode,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [15:0]       gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [15:0]       ldtLimit,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [31:0]       memData,
  output logic              done,
  output logic              zf,
  output logic              badOp,
  output logic [31:0]       rights
);

  segStrobe_t strobe;
  logic       earlyPass;

  segchk_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .earlyPass (earlyPass),
    .memValid  (memValid),
    .strobe    (strobe),
    .memReq    (memReq),
    .done      (done)
  );

  segchk_datapath #(.ADDR_W(ADDR_W), .SEL_W(16)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .selector  (selector),
    .cpl       (cpl),
    .opSize32  (opSize32),
    .protMode  (protMode),
    .gdtBase   (gdtBase),
    .gdtLimit  (gdtLimit),
    .ldtBase   (ldtBase),
    .ldtLimit  (ldtLimit),
    .memData   (memData),
    .earlyPass (earlyPass),
    .memAddr   (memAddr),
    .zf        (zf),
    .badOp     (badOp),
    .rights    (rights)
  );

  // R11
  fail_keeps_rights_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !zf |-> $stable(rights));
  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && $past(memReq) |-> $stable(memAddr));

endmodule

// File: tb/segAccessCheck_tb_top.sv
`timescale 1ns/1ps
module segAccessCheck_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0;
  logic        opSize32 = 1'b0;
  logic        protMode = 1'b0;
  logic [31:0] gdtBase = '0, ldtBase = '0;
  logic [15:0] gdtLimit = '0, ldtLimit = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        done, zf, badOp;
  logic [31:0] rights;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] expRights = '0;

  always #2 clk = ~clk;

  segAccessCheck #(.ADDR_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .selector(selector), .cpl(cpl),
    .opSize32(opSize32), .protMode(protMode), .gdtBase(gdtBase),
    .gdtLimit(gdtLimit), .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .done(done), .zf(zf), .badOp(badOp), .rights(rights)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---- reference model ----
  function automatic logic modelEarly(input logic [15:0] s, input logic pm,
                                      input logic [15:0] gl, input logic [15:0] ll);
    logic [15:0] lim;
    lim = s[2] ? ll : gl;
    return pm && (s[15:2] != 0) && ({s[15:3], 3'b111} <= lim);
  endfunction

  function automatic logic modelPass(input logic [31:0] d, input logic [1:0] c,
                                     input logic [1:0] r);
    logic tOk, conf, pOk;
    logic [1:0] lvl;
    conf = d[12] && d[11] && d[10];
    if (d[12]) tOk = 1'b1;
    else tOk = (d[11:8] inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd11, 4'd12});
    lvl = (c > r) ? c : r;
    pOk = conf || (lvl <= d[14:13]);
    return tOk && pOk;
  endfunction

  function automatic logic [31:0] modelMask(input logic [31:0] d, input logic w);
    return w ? (d & 32'h00F0FF00) : {16'h0, d[15:8], 8'h00};
  endfunction

  task automatic runOp(input logic [15:0] s, input logic [1:0] c, input logic w,
                       input logic pm, input logic [31:0] desc, input int lat,
                       input logic poke, input string tag);
    logic early, ok;
    logic [31:0] expAddr;
    @(negedge clk);
    selector = s; cpl = c; opSize32 = w; protMode = pm; start = 1'b1;
    early = modelEarly(s, pm, gdtLimit, ldtLimit);
    expAddr = (s[2] ? ldtBase : gdtBase) + {16'h0, s[15:3], 3'b100};
    @(negedge clk);
    start = 1'b0;
    if (!early) begin
      chk({tag, " R2/R3/R4 done"}, {31'b0, done}, 32'd1);
      chk({tag, " R3/R4 memReq"}, {31'b0, memReq}, 32'd0);
      chk({tag, " R2 badOp"}, {31'b0, badOp}, {31'b0, !pm});
      chk({tag, " R11 zf"}, {31'b0, zf}, 32'd0);
      chk({tag, " R11 rights"}, rights, expRights);
    end else begin
      chk({tag, " R5 memReq"}, {31'b0, memReq}, 32'd1);
      chk({tag, " R5 memAddr"}, memAddr, expAddr);
      for (int i = 0; i < lat; i++) begin
        if (poke && i == 0) begin
          selector = 16'h0000; protMode = 1'b0; start = 1'b1;   // R12
        end
        @(negedge clk);
        start = 1'b0; selector = s; protMode = pm;
        chk({tag, " R12 no done while waiting"}, {31'b0, done}, 32'd0);
        chk({tag, " R5 memReq held"}, {31'b0, memReq}, 32'd1);
        chk({tag, " R5 memAddr held"}, memAddr, expAddr);
      end
      memValid = 1'b1; memData = desc;
      @(negedge clk);
      memValid = 1'b0; memData = $urandom;
      ok = modelPass(desc, c, s[1:0]);
      if (ok) expRights = modelMask(desc, w);
      chk({tag, " R5 done"}, {31'b0, done}, 32'd1);
      chk({tag, " R5 memReq drop"}, {31'b0, memReq}, 32'd0);
      chk({tag, " R6/R7/R8 zf"}, {31'b0, zf}, {31'b0, ok});
      chk({tag, " R11 badOp"}, {31'b0, badOp}, 32'd0);
      chk({tag, w ? " R9 rights" : " R10 rights"}, rights, expRights);
      if (poke) begin
        @(negedge clk);
        chk({tag, " R12 single done"}, {31'b0, done}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    gdtBase = 32'h0001_0000; ldtBase = 32'h0800_0040;
    gdtLimit = 16'h00FF; ldtLimit = 16'h003F;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 zf", {31'b0, zf}, 32'd0);
    chk("R1 badOp", {31'b0, badOp}, 32'd0);
    chk("R1 memReq", {31'b0, memReq}, 32'd0);
    chk("R1 rights", rights, 32'd0);

    // directed corners
    runOp(16'h0010, 2'd0, 1'b1, 1'b0, 32'h0, 0, 1'b0, "R2 realmode");
    runOp(16'h0003, 2'd0, 1'b1, 1'b1, 32'h0, 0, 1'b0, "R3 null");
    runOp(16'h0004, 2'd0, 1'b1, 1'b1, 32'hFFFF_FAFF, 1, 1'b0, "R3 ldt idx0");
    runOp(16'h00F8, 2'd0, 1'b1, 1'b1, 32'h0, 0, 1'b0, "R4 gdt last ok");
    runOp(16'h0100, 2'd0, 1'b1, 1'b1, 32'h0, 0, 1'b0, "R4 gdt over");
    runOp(16'h0040 | 16'h4, 2'd0, 1'b1, 1'b1, 32'h0, 0, 1'b0, "R4 ldt over");
    runOp(16'h0008, 2'd3, 1'b1, 1'b1, 32'h00CF_9A00, 2, 1'b0, "R8 low dpl code");
    runOp(16'h0008, 2'd3, 1'b1, 1'b1, 32'h00CF_9E00, 2, 1'b0, "R8 conforming");
    runOp(16'h000B, 2'd0, 1'b0, 1'b1, 32'h00CF_F200, 1, 1'b0, "R10 data dpl3");
    runOp(16'h0010, 2'd0, 1'b1, 1'b1, 32'hABCD_8900, 0, 1'b0, "R7 type9");
    runOp(16'h0010, 2'd0, 1'b1, 1'b1, 32'hABCD_8D00, 0, 1'b0, "R7 type13");
    runOp(16'h0010, 2'd0, 1'b1, 1'b1, 32'hABCD_8800, 0, 1'b0, "R7 type8");
    runOp(16'h0018, 2'd0, 1'b1, 1'b1, 32'h12F5_9300, 3, 1'b1, "R12 poke");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [15:0] s;
      logic [31:0] d;
      gdtLimit = 16'($urandom_range(0, 16'hFFFF));
      ldtLimit = 16'($urandom_range(0, 16'h0FFF));
      gdtBase  = $urandom;
      ldtBase  = $urandom;
      s = 16'($urandom);
      if ($urandom_range(0, 3) == 0) s[15:8] = 8'h00;
      d = $urandom;
      runOp(s, 2'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0), d,
            $urandom_range(0, 3), ($urandom_range(0, 15) == 0), "random");
    end

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule